// File: doc/BRIEF.md
# Two-Wire Clocked Word Link

This block moves data words from a source endpoint to a sink endpoint over a single-clock channel that carries a data bus and two control wires. The source raises `link_have` in the cycle its word becomes valid on `link_data`. It keeps both steady until the sink answers with `link_got`. The sink raises `link_got` for exactly one cycle once it has captured the word. The source then lowers `link_have` and clears the bus. That falling edge tells the sink that its pulse was seen, and it is the only thing that lets the sink take another word.

On the local side, the source takes a word when `in_push` is high in a cycle where `in_ready` is high. The sink presents each captured word on `out_data`, with `out_valid` high for one cycle. The parameter `SINK_WAIT` makes the sink hold off for that many cycles after it first sees `link_have`, which models a slow receiver.

Top module: `hg_link`

## Requirements
- R1: After reset, `in_ready` is 1 and `link_have`, `link_got` and `out_valid` are 0.
- R2: A word accepted on a clock edge (`in_push` and `in_ready` both high) appears on `out_data`, with `out_valid` high, exactly `SINK_WAIT`+1 clock edges later.
- R3: `link_got` is high for exactly one cycle per transfer. That cycle is the cycle in which `out_valid` is high, and `link_have` is high during it.
- R4: In the cycle after `link_got` is high, `link_have` is 0. Whenever `link_have` is 0, `link_data` reads all zeros.
- R5: While `link_have` is high and `link_got` is low, the next cycle still has `link_have` high and an unchanged `link_data`.
- R6: After `link_have` falls, it stays 0 for at least the next cycle, and `in_ready` is 1 in that next cycle.
- R7: `in_ready` is 0 whenever `link_have` is 1. A push made while `in_ready` is 0 is ignored and never reaches `out_data`.
- R8: The sink captures each transfer exactly once. Words leave in the order they were accepted, with no loss and no repeat, for any `SINK_WAIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; every control wire changes only on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_push | input | 1 | Local request to send `in_data` |
| in_data | input | DATA_W | Word offered by the local side |
| in_ready | output | 1 | Source is idle and will take a push |
| out_valid | output | 1 | One-cycle strobe: `out_data` holds a newly captured word |
| out_data | output | DATA_W | Last word captured by the sink |
| link_have | output | 1 | Channel wire from source: data on the bus is valid |
| link_got | output | 1 | Channel wire from sink: one-cycle capture pulse |
| link_data | output | DATA_W | Channel data bus, zero when not driven |

## Verification
The bench streams word sequences through two copies of the link, one with an immediate sink and one with a three-cycle sink wait. It interleaves idle gaps with pushes made while the source is busy.

A sink that ignored the acknowledging fall of `link_have` would capture the same word twice, and the scoreboard would flag this as a repeat. A source that took pushes while busy would leak the marker value `8'hEE` into the output. A `link_got` that stayed high, or a source that did not drop `link_have` right after the pulse, breaks the cycle-by-cycle checks on the wires. A sink whose wait count is off by one misses the exact arrival cycle the bench computes from `SINK_WAIT`.

// File: rtl/hg_pkg.sv
package hg_pkg;
   typedef enum logic [1:0] {
      SRC_IDLE = 2'd0,
      SRC_HOLD = 2'd1,
      SRC_GAP  = 2'd2
   } src_state_t;
endpackage

// File: rtl/hg_src.sv
module hg_src #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   output logic              ready,
   input  logic              got,
   output logic              have,
   output logic [DATA_W-1:0] bus
);
   import hg_pkg::*;

   src_state_t        st;
   logic [DATA_W-1:0] word_q;
   logic              have_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= SRC_IDLE;
         word_q <= '0;
         have_q <= 1'b0;
      end else begin
         unique case (st)
            SRC_IDLE: if (push) begin
               word_q <= push_data;
               have_q <= 1'b1;
               st     <= SRC_HOLD;
            end
            SRC_HOLD: if (got) begin
               word_q <= '0;
               have_q <= 1'b0;
               st     <= SRC_GAP;
            end
            SRC_GAP:  st <= SRC_IDLE;
            default:  st <= SRC_IDLE;
         endcase
      end
   end

   assign ready = (st == SRC_IDLE);
   assign have  = have_q;
   assign bus   = word_q;
endmodule

// File: rtl/hg_sink.sv
module hg_sink #(
   parameter int DATA_W    = 8,
   parameter int SINK_WAIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              have,
   input  logic [DATA_W-1:0] bus,
   output logic              got,
   output logic              vld,
   output logic [DATA_W-1:0] dat
);
   localparam int CNT_W = (SINK_WAIT > 0) ? $clog2(SINK_WAIT + 1) : 1;

   logic armed;
   logic wait_done;
   logic load;

   assign load = armed && have && wait_done;

   generate
      if (SINK_WAIT == 0) begin : g_fast
         assign wait_done = 1'b1;
      end else begin : g_slow
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (load)
               cnt <= '0;
            else if (armed && have)
               cnt <= cnt + 1'b1;
         end
         assign wait_done = (cnt == CNT_W'(SINK_WAIT));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b1;
         got   <= 1'b0;
         vld   <= 1'b0;
         dat   <= '0;
      end else begin
         got <= 1'b0;
         vld <= 1'b0;
         if (load) begin
            dat   <= bus;
            got   <= 1'b1;
            vld   <= 1'b1;
            armed <= 1'b0;
         end else if (!armed && !have) begin
            armed <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/hg_link.sv
module hg_link #(
   parameter int DATA_W    = 8,
   parameter int SINK_WAIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_push,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              link_have,
   output logic              link_got,
   output logic [DATA_W-1:0] link_data
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("hg_link: DATA_W must be at least 1");
      end
      if (SINK_WAIT < 0) begin : g_bad_wait
         $error("hg_link: SINK_WAIT must not be negative");
      end
   endgenerate

   hg_src #(.DATA_W(DATA_W)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (in_push),
      .push_data (in_data),
      .ready     (in_ready),
      .got       (link_got),
      .have      (link_have),
      .bus       (link_data)
   );

   hg_sink #(.DATA_W(DATA_W), .SINK_WAIT(SINK_WAIT)) u_sink (
      .clk   (clk),
      .rst_n (rst_n),
      .have  (link_have),
      .bus   (link_data),
      .got   (link_got),
      .vld   (out_valid),
      .dat   (out_data)
   );
endmodule

// File: rtl/hg_link_chk.sv
module hg_link_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              out_valid,
   input logic              link_have,
   input logic              link_got,
   input logic [DATA_W-1:0] link_data
);
   a_r3_got_single: assert property (@(posedge clk) disable iff (!rst_n)
      link_got |=> !link_got);
   a_r3_got_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      link_got |-> (out_valid && link_have));
   a_r4_have_drops: assert property (@(posedge clk) disable iff (!rst_n)
      link_got |=> (!link_have && link_data == '0));
   a_r4_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !link_have |-> (link_data == '0));
   a_r5_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (link_have && !link_got) |=> (link_have && $stable(link_data)));
   a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_have) |=> (!link_have && in_ready));
   a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      link_have |-> !in_ready);
endmodule

bind hg_link hg_link_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .link_have (link_have),
   .link_got  (link_got),
   .link_data (link_data)
);

// File: tb/tb_hg_link.sv
module tb_hg_link;
   localparam int DW = 8;
   localparam int NW = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   logic done0 = 1'b0;
   logic done1 = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   for (genvar g = 0; g < 2; g++) begin : g_lane
      localparam int W = (g == 0) ? 0 : 3;
      logic          push = 1'b0;
      logic [DW-1:0] din = '0;
      logic          rdy, ov, hv, gt;
      logic [DW-1:0] dout, ld;
      int            exp_cyc [NW];
      int            rx = 0;

      if (g == 0) begin : g_dut0
         hg_link #(.DATA_W(DW), .SINK_WAIT(W)) dut (
            .clk(clk), .rst_n(rst_n), .in_push(push), .in_data(din),
            .in_ready(rdy), .out_valid(ov), .out_data(dout),
            .link_have(hv), .link_got(gt), .link_data(ld));
      end else begin : g_dut1
         hg_link #(.DATA_W(DW), .SINK_WAIT(W)) dut (
            .clk(clk), .rst_n(rst_n), .in_push(push), .in_data(din),
            .in_ready(rdy), .out_valid(ov), .out_data(dout),
            .link_have(hv), .link_got(gt), .link_data(ld));
      end

      function automatic logic [DW-1:0] word(input int k);
         return DW'(g * 100 + k * 5 + 3);
      endfunction

      // driver: varied gaps, marker pushes while busy (R7)
      initial begin
         int k = 0;
         int n = 0;
         @(posedge rst_n);
         while (k < NW) begin
            @(negedge clk);
            push = 1'b0;
            if (rdy) begin
               if ((n % 3) != 1 || k > 14) begin
                  push = 1'b1;
                  din  = word(k);
                  exp_cyc[k] = cyc + W + 2;
                  k++;
               end
            end else if ((n % 2) == 0) begin
               push = 1'b1;
               din  = 8'hEE;
            end
            n++;
         end
         @(negedge clk);
         push = 1'b0;
      end

      // monitor
      logic p_hv = 1'b0, p_gt = 1'b0;
      logic [DW-1:0] p_ld = '0;
      bit   fell = 1'b0;
      always @(negedge clk) begin
         if (rst_n) begin
            if (ov) begin
               if (rx < NW) begin
                  chk(dout == word(rx), "R8 order/value", dout, word(rx));
                  chk(cyc == exp_cyc[rx], "R2 arrival cycle", cyc, exp_cyc[rx]);
               end else begin
                  chk(1'b0, "R8 extra word", dout, 0);
               end
               chk(dout != 8'hEE, "R7 ignored push leaked", dout, 0);
               rx++;
            end
            chk(gt == ov, "R3 got matches out_valid", gt, ov);
            if (gt) chk(hv, "R3 have high during got", hv, 1);
            if (p_gt) begin
               chk(!gt, "R3 got single cycle", gt, 0);
               chk(!hv, "R4 have drops after got", hv, 0);
            end
            if (!hv) chk(ld == '0, "R4 bus zero when idle", ld, 0);
            if (p_hv && !p_gt) begin
               chk(hv, "R5 have held", hv, 1);
               chk(ld == p_ld, "R5 data held", ld, p_ld);
            end
            if (fell) begin
               chk(!hv, "R6 gap low", hv, 0);
               chk(rdy, "R6 ready after gap", rdy, 1);
            end
            if (hv) chk(!rdy, "R7 busy not ready", rdy, 0);
            fell = p_hv && !hv;
            p_hv = hv;
            p_gt = gt;
            p_ld = ld;
            if (rx >= NW) begin
               if (g == 0) done0 = 1'b1; else done1 = 1'b1;
            end
         end
      end
   end

   initial begin
      int t = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(g_lane[0].rdy && !g_lane[0].hv && !g_lane[0].gt && !g_lane[0].ov,
          "R1 reset state lane0", g_lane[0].rdy, 1);
      chk(g_lane[1].rdy && !g_lane[1].hv && !g_lane[1].gt && !g_lane[1].ov,
          "R1 reset state lane1", g_lane[1].rdy, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(g_lane[0].rdy && !g_lane[0].hv, "R1 idle after reset", g_lane[0].rdy, 1);
      while (!(done0 && done1) && t < 5000) begin
         @(negedge clk);
         t++;
      end
      if (!(done0 && done1)) chk(1'b0, "R8 watchdog expired", t, 5000);
      repeat (20) @(negedge clk);
      chk(g_lane[0].rx == NW, "R8 count lane0", g_lane[0].rx, NW);
      chk(g_lane[1].rx == NW, "R8 count lane1", g_lane[1].rx, NW);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule